// File: doc/BRIEF.md
# Rotating-Parity Small-Write Controller

This block sits in front of a striped array of `NUM_DISKS` small disks. Each disk is modelled as a synchronous RAM with one word per stripe. The block takes one logical request at a time. A request carries an opcode, a logical block number and, for a write, a data word. The block turns the block number into a stripe row and a data disk. It also works out which disk holds parity for that stripe. The parity disk moves from stripe to stripe, so parity is spread over every disk and no single disk carries all the parity traffic.

A logical write updates parity without reading the other data disks of the stripe. The block reads the old data and the old parity. It forms the new parity as old parity XOR old data XOR new data. It then writes the new data, followed by the new parity. A logical read accesses only the target data disk and returns the stored word together with the done pulse. The caller must present block numbers below `STRIPES*(NUM_DISKS-1)`. Each disk port returns read data in the cycle after a read access.

Top module: `raid5_small_write`

## Requirements
- R1: After reset, `req_ready_o` is 1, `done_o` is 0 and no disk enable is set.
- R2: Let b be the block number. Its stripe is b / (N-1) and its position is q = b mod (N-1). The data disk is q when q is below the parity disk, and q+1 otherwise. Every access of the request uses the stripe as the disk address, and a write leaves the new word at that address of the data disk.
- R3: The parity disk for stripe s is (N-1) - (s mod N).
- R4: A write makes exactly four disk accesses, one per cycle in consecutive cycles, starting the cycle after acceptance: read the data disk, read the parity disk, write the data disk, write the parity disk. No write is issued before both reads.
- R5: The written parity is old parity XOR old data XOR new data. An array that starts at all zeros therefore keeps the XOR of the N words in every stripe at zero.
- R6: A read makes exactly one access, a non-write access to the data disk. `rsp_data_o` holds the stored word while `done_o` is high.
- R7: `done_o` is a single-cycle pulse. It is high in the 5th cycle after acceptance for a write (the cycle after the parity write) and in the 3rd cycle after acceptance for a read.
- R8: `req_ready_o` is low from the cycle after acceptance through the done cycle and high again in the cycle after it. A request held on the inputs while ready is low has no effect.
- R9: At most one disk enable is high in any cycle, and a disk write enable is only ever high together with that disk's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_wr_i | input | 1 | 1 = logical write, 0 = logical read |
| req_blk_i | input | BLK_W | Logical block number |
| req_wdata_i | input | WORD_W | Write data |
| done_o | output | 1 | Request complete pulse |
| rsp_data_o | output | WORD_W | Read data of the last logical read |
| disk_en_o | output | NUM_DISKS | Per-disk access enable |
| disk_we_o | output | NUM_DISKS | Per-disk write enable |
| disk_addr_o | output | NUM_DISKS*ADDR_W | Per-disk row address |
| disk_wdata_o | output | NUM_DISKS*WORD_W | Per-disk write data |
| disk_rdata_i | input | NUM_DISKS*WORD_W | Per-disk read data, valid the cycle after a read |

## Verification
Writes are sent to every position of stripes whose parity sits on the last disk, on a middle disk and on disk 0. This separates the two mapping branches (data index at or past the parity disk, or below it). It also catches a parity rotation that is off by one. Re-writing a block whose parity was already updated shows whether the old data is really folded into the new parity, and a full stripe XOR sweep after each write exposes any stray or missing term. Reads of written and never-written blocks, plus a request held on the inputs during a busy write, show that reads touch only one disk and that a blocked request leaves the array unchanged.

// File: rtl/raid5_sw_pkg.sv
package raid5_sw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DAT, ST_RD_PAR, ST_RD_LAT, ST_WR_DAT, ST_WR_PAR, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/raid5_map.sv
module raid5_map #(
  parameter int NUM_DISKS = 4,
  parameter int BLK_W     = 5,
  parameter int ADDR_W    = 3,
  parameter int DISK_W    = 2
) (
  input  logic [BLK_W-1:0]  blk_i,
  output logic [ADDR_W-1:0] stripe_o,
  output logic [DISK_W-1:0] data_disk_o,
  output logic [DISK_W-1:0] par_disk_o
);
  localparam int DATA_N = NUM_DISKS - 1;

  always_comb begin
    int s, q, p;
    s = int'(blk_i) / DATA_N;
    q = int'(blk_i) % DATA_N;
    p = (NUM_DISKS - 1) - (s % NUM_DISKS);
    stripe_o    = ADDR_W'(s);
    par_disk_o  = DISK_W'(p);
    // data positions skip the parity disk
    data_disk_o = (q < p) ? DISK_W'(q) : DISK_W'(q + 1);
  end
endmodule

// File: rtl/raid5_seq.sv
module raid5_seq
  import raid5_sw_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 3,
  parameter int DISK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_wr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [ADDR_W-1:0] stripe_i,
  input  logic [DISK_W-1:0] data_disk_i,
  input  logic [DISK_W-1:0] par_disk_i,
  input  logic [WORD_W-1:0] data_rd_i,
  input  logic [WORD_W-1:0] par_rd_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              acc_en_o,
  output logic              acc_we_o,
  output logic              acc_par_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [WORD_W-1:0] acc_wdata_o,
  output logic [DISK_W-1:0] cur_data_o,
  output logic [DISK_W-1:0] cur_par_o
);
  seq_state_e        state_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] stripe_q;
  logic [DISK_W-1:0] dd_q, pd_q;
  logic [WORD_W-1:0] wdata_q, old_dat_q, old_par_q, rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_wr_q   <= 1'b0;
      stripe_q  <= '0;
      dd_q      <= '0;
      pd_q      <= '0;
      wdata_q   <= '0;
      old_dat_q <= '0;
      old_par_q <= '0;
      rsp_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_wr_q  <= req_wr_i;
          stripe_q <= stripe_i;
          dd_q     <= data_disk_i;
          pd_q     <= par_disk_i;
          wdata_q  <= req_wdata_i;
          state_q  <= ST_RD_DAT;
        end
        ST_RD_DAT: state_q <= op_wr_q ? ST_RD_PAR : ST_RD_LAT;
        ST_RD_LAT: begin
          rsp_q   <= data_rd_i;
          state_q <= ST_FIN;
        end
        ST_RD_PAR: begin
          old_dat_q <= data_rd_i;
          state_q   <= ST_WR_DAT;
        end
        ST_WR_DAT: begin
          old_par_q <= par_rd_i;   // parity read issued last cycle
          state_q   <= ST_WR_PAR;
        end
        ST_WR_PAR: state_q <= ST_FIN;
        ST_FIN:    state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign rsp_data_o  = rsp_q;
  assign acc_en_o    = (state_q == ST_RD_DAT) || (state_q == ST_RD_PAR) ||
                       (state_q == ST_WR_DAT) || (state_q == ST_WR_PAR);
  assign acc_we_o    = (state_q == ST_WR_DAT) || (state_q == ST_WR_PAR);
  assign acc_par_o   = (state_q == ST_RD_PAR) || (state_q == ST_WR_PAR);
  assign acc_addr_o  = stripe_q;
  assign acc_wdata_o = (state_q == ST_WR_PAR) ? (old_par_q ^ old_dat_q ^ wdata_q)
                                              : wdata_q;
  assign cur_data_o  = dd_q;
  assign cur_par_o   = pd_q;
endmodule

// File: rtl/raid5_disk_fabric.sv
module raid5_disk_fabric #(
  parameter int NUM_DISKS = 4,
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DISK_W    = 2
) (
  input  logic                        acc_en_i,
  input  logic                        acc_we_i,
  input  logic                        acc_par_i,
  input  logic [ADDR_W-1:0]           acc_addr_i,
  input  logic [WORD_W-1:0]           acc_wdata_i,
  input  logic [DISK_W-1:0]           data_disk_i,
  input  logic [DISK_W-1:0]           par_disk_i,
  output logic [WORD_W-1:0]           data_rd_o,
  output logic [WORD_W-1:0]           par_rd_o,
  output logic [NUM_DISKS-1:0]        disk_en_o,
  output logic [NUM_DISKS-1:0]        disk_we_o,
  output logic [NUM_DISKS*ADDR_W-1:0] disk_addr_o,
  output logic [NUM_DISKS*WORD_W-1:0] disk_wdata_o,
  input  logic [NUM_DISKS*WORD_W-1:0] disk_rdata_i
);
  logic [DISK_W-1:0] tgt;
  assign tgt = acc_par_i ? par_disk_i : data_disk_i;

  for (genvar d = 0; d < NUM_DISKS; d++) begin : g_disk
    assign disk_en_o[d] = acc_en_i && (tgt == DISK_W'(d));
    assign disk_we_o[d] = disk_en_o[d] && acc_we_i;
    assign disk_addr_o[d*ADDR_W +: ADDR_W]  = acc_addr_i;
    assign disk_wdata_o[d*WORD_W +: WORD_W] = acc_wdata_i;
  end

  always_comb begin
    data_rd_o = '0;
    par_rd_o  = '0;
    for (int d = 0; d < NUM_DISKS; d++) begin
      if (data_disk_i == DISK_W'(d)) data_rd_o = disk_rdata_i[d*WORD_W +: WORD_W];
      if (par_disk_i  == DISK_W'(d)) par_rd_o  = disk_rdata_i[d*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/raid5_small_write.sv
module raid5_small_write #(
  parameter int NUM_DISKS = 4,
  parameter int STRIPES   = 8,
  parameter int WORD_W    = 8,
  parameter int BLK_W     = $clog2(STRIPES*(NUM_DISKS-1)),
  parameter int ADDR_W    = $clog2(STRIPES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_wr_i,
  input  logic [BLK_W-1:0]            req_blk_i,
  input  logic [WORD_W-1:0]           req_wdata_i,
  output logic                        done_o,
  output logic [WORD_W-1:0]           rsp_data_o,
  output logic [NUM_DISKS-1:0]        disk_en_o,
  output logic [NUM_DISKS-1:0]        disk_we_o,
  output logic [NUM_DISKS*ADDR_W-1:0] disk_addr_o,
  output logic [NUM_DISKS*WORD_W-1:0] disk_wdata_o,
  input  logic [NUM_DISKS*WORD_W-1:0] disk_rdata_i
);
  localparam int DISK_W = $clog2(NUM_DISKS);

  logic [ADDR_W-1:0] map_stripe, acc_addr;
  logic [DISK_W-1:0] map_dd, map_pd, cur_dd, cur_pd;
  logic [WORD_W-1:0] data_rd, par_rd, acc_wdata;
  logic              acc_en, acc_we, acc_par;

  raid5_map #(.NUM_DISKS(NUM_DISKS), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .DISK_W(DISK_W)) u_map (
    .blk_i(req_blk_i), .stripe_o(map_stripe), .data_disk_o(map_dd), .par_disk_o(map_pd)
  );

  raid5_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DISK_W(DISK_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_wr_i, .req_wdata_i,
    .stripe_i(map_stripe), .data_disk_i(map_dd), .par_disk_i(map_pd),
    .data_rd_i(data_rd), .par_rd_i(par_rd),
    .req_ready_o, .done_o, .rsp_data_o,
    .acc_en_o(acc_en), .acc_we_o(acc_we), .acc_par_o(acc_par),
    .acc_addr_o(acc_addr), .acc_wdata_o(acc_wdata),
    .cur_data_o(cur_dd), .cur_par_o(cur_pd)
  );

  raid5_disk_fabric #(.NUM_DISKS(NUM_DISKS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DISK_W(DISK_W)) u_fab (
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_par_i(acc_par),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .data_disk_i(cur_dd), .par_disk_i(cur_pd),
    .data_rd_o(data_rd), .par_rd_o(par_rd),
    .disk_en_o, .disk_we_o, .disk_addr_o, .disk_wdata_o, .disk_rdata_i
  );
endmodule

// File: rtl/raid5_small_write_chk.sv
module raid5_small_write_chk #(
  parameter int NUM_DISKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_wr_i,
  input logic                 req_ready_o,
  input logic                 done_o,
  input logic [NUM_DISKS-1:0] disk_en_o,
  input logic [NUM_DISKS-1:0] disk_we_o
);
  logic                 op_wr, any_we, acc_ok;
  logic [1:0]           rd_cnt;
  logic                 wr_cnt;
  logic [NUM_DISKS-1:0] first_wr_en;

  assign any_we = |disk_we_o;
  assign acc_ok = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_wr       <= 1'b0;
      rd_cnt      <= '0;
      wr_cnt      <= 1'b0;
      first_wr_en <= '0;
    end else if (acc_ok) begin
      op_wr  <= req_wr_i;
      rd_cnt <= '0;
      wr_cnt <= 1'b0;
    end else begin
      if ((|disk_en_o) && !any_we && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
      if (any_we) begin
        wr_cnt <= 1'b1;
        if (!wr_cnt) first_wr_en <= disk_en_o;
      end
    end
  end

  p_one_disk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disk_en_o));
  p_we_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disk_we_o & ~disk_en_o) == '0);
  p_reads_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_we |-> (op_wr && rd_cnt == 2'd2));
  p_two_targets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_we && wr_cnt) |-> (disk_en_o != first_wr_en));
  p_read_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_wr && (|disk_en_o)) |-> (rd_cnt == 2'd0 && !any_we));
  p_done_after_par_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_we && wr_cnt) |=> done_o);
  p_busy_after_acc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> !req_ready_o);
  p_ready_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (req_ready_o && !done_o));
endmodule

bind raid5_small_write raid5_small_write_chk #(.NUM_DISKS(NUM_DISKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_wr_i(req_wr_i),
  .req_ready_o(req_ready_o), .done_o(done_o),
  .disk_en_o(disk_en_o), .disk_we_o(disk_we_o)
);

// File: tb/tb_raid5_small_write.sv
`timescale 1ns/1ps
module tb_raid5_small_write;
  localparam int N      = 4;
  localparam int ST     = 8;
  localparam int W      = 8;
  localparam int BLK_W  = $clog2(ST*(N-1));
  localparam int AW     = $clog2(ST);
  localparam int TOTAL  = ST*(N-1);

  typedef struct packed {
    logic       wr;
    logic [4:0] blk;
    logic [7:0] dat;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{1'b1, 5'd0,  8'hA5, 8'h00}, '{1'b1, 5'd1,  8'h3C, 8'h00},
    '{1'b1, 5'd2,  8'hF0, 8'h00}, '{1'b1, 5'd4,  8'h5A, 8'h00},
    '{1'b1, 5'd5,  8'h81, 8'h00}, '{1'b1, 5'd3,  8'h66, 8'h00},
    '{1'b1, 5'd9,  8'h12, 8'h00}, '{1'b1, 5'd10, 8'h34, 8'h00},
    '{1'b1, 5'd11, 8'hC7, 8'h00}, '{1'b1, 5'd12, 8'h99, 8'h00},
    '{1'b1, 5'd23, 8'hE1, 8'h00}, '{1'b0, 5'd4,  8'h00, 8'h5A},
    '{1'b0, 5'd11, 8'h00, 8'hC7}, '{1'b0, 5'd23, 8'h00, 8'hE1},
    '{1'b0, 5'd0,  8'h00, 8'hA5}, '{1'b1, 5'd4,  8'h0F, 8'h00},
    '{1'b0, 5'd4,  8'h00, 8'h0F}, '{1'b0, 5'd7,  8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               req_valid = 1'b0, req_wr = 1'b0;
  logic [BLK_W-1:0]   req_blk = '0;
  logic [W-1:0]       req_wdata = '0;
  logic               req_ready, done;
  logic [W-1:0]       rsp_data;
  logic [N-1:0]       disk_en, disk_we;
  logic [N*AW-1:0]    disk_addr;
  logic [N*W-1:0]     disk_wdata;
  logic [N*W-1:0]     disk_rdata;

  raid5_small_write #(.NUM_DISKS(N), .STRIPES(ST), .WORD_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_wr_i(req_wr), .req_blk_i(req_blk), .req_wdata_i(req_wdata),
    .done_o(done), .rsp_data_o(rsp_data), .disk_en_o(disk_en), .disk_we_o(disk_we),
    .disk_addr_o(disk_addr), .disk_wdata_o(disk_wdata), .disk_rdata_i(disk_rdata)
  );

  // disk models: synchronous RAMs, read data one cycle after the access
  logic [W-1:0] mem [N][ST];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < N; d++) for (int a = 0; a < ST; a++) mem[d][a] <= '0;
      disk_rdata <= '0;
    end else begin
      for (int d = 0; d < N; d++)
        if (disk_en[d]) begin
          if (disk_we[d]) mem[d][disk_addr[d*AW +: AW]] <= disk_wdata[d*W +: W];
          else disk_rdata[d*W +: W] <= mem[d][disk_addr[d*AW +: AW]];
        end
    end
  end

  int total = 0, bad = 0, cyc = 0, multi_hot = 0;
  int log_n = 0;
  int log_disk [8];
  int log_we   [8];
  int log_addr [8];

  always @(negedge clk) begin
    if (rst_n && |disk_en) begin
      if ($countones(disk_en) > 1) multi_hot++;
      if (log_n < 8) begin
        for (int d = 0; d < N; d++)
          if (disk_en[d]) begin
            log_disk[log_n] = d;
            log_we[log_n]   = int'(disk_we[d]);
            log_addr[log_n] = int'(disk_addr[d*AW +: AW]);
          end
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int par_of(int s);
    return (N-1) - (s % N);
  endfunction
  function automatic int dd_of(int b);
    int q, p;
    q = b % (N-1);
    p = par_of(b / (N-1));
    return (q < p) ? q : q + 1;
  endfunction

  task automatic stripe_sweep();
    int errs = 0;
    for (int a = 0; a < ST; a++) begin
      logic [W-1:0] x = '0;
      for (int d = 0; d < N; d++) x ^= mem[d][a];
      if (x != '0) errs++;
    end
    chk(errs == 0, "R5 stripes with nonzero xor", errs, 0);
  endtask

  task automatic do_req(input bit wr, input int blk, input logic [W-1:0] dat,
                        input logic [W-1:0] exp, input bit noise);
    int lat, s, dd, pd;
    logic [W-1:0] got;
    s  = blk / (N-1);
    dd = dd_of(blk);
    pd = par_of(s);
    log_n = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_wr = wr; req_blk = BLK_W'(blk); req_wdata = dat;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      req_wr = 1'b1; req_blk = BLK_W'((blk + 1) % TOTAL); req_wdata = ~dat;
    end else req_valid = 1'b0;
    chk(req_ready === 1'b0, "R8 ready low while busy", int'(req_ready), 0);
    lat = 1;
    while (done !== 1'b1 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    got = rsp_data;
    chk(lat == (wr ? 5 : 3), "R7 done latency", lat, wr ? 5 : 3);
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0, "R8 ready back, R7 single pulse",
        int'(req_ready) * 2 + int'(done), 2);
    if (wr) begin
      chk(log_n == 4, "R4 access count", log_n, 4);
      if (log_n == 4) begin
        chk(log_disk[0] == dd && log_we[0] == 0, "R4 step1 read data disk", log_disk[0], dd);
        chk(log_disk[1] == pd && log_we[1] == 0, "R3 step2 read parity disk", log_disk[1], pd);
        chk(log_disk[2] == dd && log_we[2] == 1, "R4 step3 write data disk", log_disk[2], dd);
        chk(log_disk[3] == pd && log_we[3] == 1, "R3 step4 write parity disk", log_disk[3], pd);
        for (int k = 0; k < 4; k++)
          chk(log_addr[k] == s, "R2 row address", log_addr[k], s);
      end
      chk(mem[dd][s] == dat, "R2 data landed on data disk", int'(mem[dd][s]), int'(dat));
      stripe_sweep();
    end else begin
      chk(log_n == 1, "R6 read access count", log_n, 1);
      if (log_n == 1)
        chk(log_disk[0] == dd && log_we[0] == 0 && log_addr[0] == s,
            "R6 read hits data disk only", log_disk[0], dd);
      chk(got == exp, "R6 read data", int'(got), int'(exp));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && disk_en === '0, "R1 state in reset",
        int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && disk_en === '0, "R1 state after reset",
        int'(disk_en), 0);

    for (int i = 0; i < 18; i++)
      do_req(VEC[i].wr, int'(VEC[i].blk), VEC[i].dat, VEC[i].exp, 1'b0);

    // R8: request held during a busy write (blk 7, ~data) must not be taken
    do_req(1'b1, 6, 8'h77, 8'h00, 1'b1);
    do_req(1'b0, 7, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 6, 8'h00, 8'h77, 1'b0);
    // R3 boundary: stripe 7 parity on disk 0, last position
    do_req(1'b1, 22, 8'h3B, 8'h00, 1'b0);
    do_req(1'b0, 22, 8'h00, 8'h3B, 1'b0);

    chk(multi_hot == 0, "R9 cycles with several disks enabled", multi_hot, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule